// File: doc/BRIEF.md
# OTG Edge-Event Interrupt Controller

This block collects interrupt events for a USB OTG wrapper and presents them to a processor through a small 32-bit register window. It watches four control signals that the OTG core drives toward the PHY: the VBUS drive request, the VBUS charge request, the VBUS discharge request and the ID pull-up enable. It records a separate event for every rising edge and every falling edge of each. It also latches an OTG event from the core and an event raised when software clears the DMA-disable flag in a configuration register. The core's main interrupt is collected in a second, independent group.

Each group has a raw status view, a masked status view, and write-one-to-set and write-one-to-clear enable registers. Each group drives a level interrupt output. Software acknowledges events by writing back the value it read from the masked status register. An end-of-interrupt write deasserts the chosen output for exactly one cycle, so a downstream edge-sensitive controller sees a fresh edge when events are still pending. All inputs are assumed to be synchronous to `clk`.

Top module: `otg_evt_irq`

## Requirements
- R1: After reset every status bit, every enable bit and the configuration flag are 0, every register reads 0, and both interrupt outputs are low.
- R2: A rising edge on `vbus_drive`, `vbus_charge`, `vbus_discharge` or `id_pullup_en` sets misc status bit 13, 12, 11 or 8 respectively. The status bit becomes visible after the first clock edge at which the new input level is sampled. The edge is judged against the level held in one register stage, which resets to 0.
- R3: A falling edge on `vbus_drive`, `vbus_charge`, `vbus_discharge` or `id_pullup_en` sets misc status bit 5, 4, 3 or 0 respectively, with the same timing as R2.
- R4: While `core_otg_evt` is high at a clock edge, misc status bit 16 is set. While `core_irq` is high at a clock edge, line-0 status bit 0 is set. Both bits stay set after the input falls.
- R5: The configuration register at 0x10 holds a DMA-disable flag in bit 16 that software can read and write. A write that changes that flag from 1 to 0 sets misc status bit 17. A write of 0 while the flag is already 0 sets nothing.
- R6: Raw status reads at 0x24 for line 0 and at 0x34 for misc. Masked status, which is raw AND enable, reads at 0x28 for line 0 and at 0x38 for misc. Only line-0 bit 0 and misc bits 17, 16, 13, 12, 11, 8, 5, 4, 3 and 0 are ever 1.
- R7: Writing 1 to a bit of the enable-set register (0x2C line 0, 0x3C misc) enables that source. Writing 1 to a bit of the enable-clear register (0x30 line 0, 0x40 misc) disables it. Zero bits leave enables unchanged. Both addresses of a group read back its enable mask, limited to the defined bits.
- R8: A write of 1 to a bit at a masked status address (0x28, 0x38) clears that status bit. Writes to the raw status addresses are ignored. If a new event for a bit arrives in the same cycle as its clear, the bit stays set.
- R9: `irq_line0` and `irq_misc` are high exactly when their group's masked status is nonzero, except as stated in R10.
- R10: A write to 0x20 acknowledges one line: bit 0 = 0 selects line 0 and bit 0 = 1 selects misc. The selected output is low for the one cycle after the write edge and then follows R9 again. The register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| vbus_drive | input | 1 | Watched VBUS drive request |
| vbus_charge | input | 1 | Watched VBUS charge request |
| vbus_discharge | input | 1 | Watched VBUS discharge request |
| id_pullup_en | input | 1 | Watched ID pull-up enable |
| core_otg_evt | input | 1 | OTG event from the core |
| core_irq | input | 1 | Main interrupt from the core |
| irq_line0 | output | 1 | Level interrupt for line 0 |
| irq_misc | output | 1 | Level interrupt for the misc group |

## Verification
The bench targets several corner cases.
- It produces an edge in the same cycle as a write-one-to-clear of that bit. A design where the clear wins would lose the event and leave the output low.
- It writes to the raw status addresses and writes zero words to the enable registers. Decoding either as a clear would drop pending bits or enables.
- It writes 0 to the DMA-disable flag both when the flag is set and when it is already clear. Treating any write of 0 as a clear would raise bit 17 falsely.
- It acknowledges each line in turn while events remain pending. A design that acknowledges the wrong line, or holds the output low for other than one cycle, shows up in the per-cycle comparison of both outputs.

// File: rtl/otg_evt_irq.sv
module otg_evt_irq #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              vbus_drive,
  input  logic              vbus_charge,
  input  logic              vbus_discharge,
  input  logic              id_pullup_en,
  input  logic              core_otg_evt,
  input  logic              core_irq,
  output logic              irq_line0,
  output logic              irq_misc
);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_RAW0  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_STS0  = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_RAWM  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_STSM  = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_SETM  = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_CLRM  = ADDR_W'(8'h40);
  localparam logic [31:0]       MASK0   = 32'h0000_0001;
  localparam logic [31:0]       MASKM   = 32'h0003_3939;
  localparam int                DMA_BIT = 16;

  logic [3:0]  watch, watch_q, rise, fall;
  logic [31:0] raw0, rawm, en0, enm, ev_m;
  logic        dma_flag, dma_clr_ev;
  logic [1:0]  eoi_hold;
  logic        wr;

  assign watch = {id_pullup_en, vbus_discharge, vbus_charge, vbus_drive};
  assign rise  = watch & ~watch_q;
  assign fall  = ~watch & watch_q;
  assign wr    = bus_sel & bus_we;
  assign dma_clr_ev = wr && bus_addr == A_CFG && dma_flag && !bus_wdata[DMA_BIT];

  always_comb begin
    ev_m     = '0;
    ev_m[13] = rise[0];
    ev_m[12] = rise[1];
    ev_m[11] = rise[2];
    ev_m[8]  = rise[3];
    ev_m[5]  = fall[0];
    ev_m[4]  = fall[1];
    ev_m[3]  = fall[2];
    ev_m[0]  = fall[3];
    ev_m[16] = core_otg_evt;
    ev_m[17] = dma_clr_ev;
  end

  function automatic logic [31:0] hit(input logic [ADDR_W-1:0] a, input logic [31:0] m);
    return (wr && bus_addr == a) ? (bus_wdata & m) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watch_q  <= '0;
      raw0     <= '0;
      rawm     <= '0;
      en0      <= '0;
      enm      <= '0;
      dma_flag <= 1'b0;
      eoi_hold <= '0;
    end else begin
      watch_q  <= watch;
      raw0     <= (raw0 & ~hit(A_STS0, MASK0)) | {31'b0, core_irq};
      rawm     <= (rawm & ~hit(A_STSM, MASKM)) | ev_m;
      en0      <= (en0 | hit(A_SET0, MASK0)) & ~hit(A_CLR0, MASK0);
      enm      <= (enm | hit(A_SETM, MASKM)) & ~hit(A_CLRM, MASKM);
      if (wr && bus_addr == A_CFG) dma_flag <= bus_wdata[DMA_BIT];
      eoi_hold <= (wr && bus_addr == A_EOI) ? (bus_wdata[0] ? 2'b10 : 2'b01) : 2'b00;
    end
  end

  assign irq_line0 = |(raw0 & en0) & ~eoi_hold[0];
  assign irq_misc  = |(rawm & enm) & ~eoi_hold[1];

  always_comb begin
    case (bus_addr)
      A_CFG:         bus_rdata = {15'b0, dma_flag, 16'b0};
      A_RAW0:        bus_rdata = raw0;
      A_STS0:        bus_rdata = raw0 & en0;
      A_SET0, A_CLR0: bus_rdata = en0;
      A_RAWM:        bus_rdata = rawm;
      A_STSM:        bus_rdata = rawm & enm;
      A_SETM, A_CLRM: bus_rdata = enm;
      default:       bus_rdata = '0;
    endcase
  end

  assert_drive_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_drive && !watch_q[0]) |=> rawm[13]);

  assert_id_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_pullup_en && watch_q[3]) |=> rawm[0]);

  assert_dma_clear_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CFG && dma_flag && !bus_wdata[DMA_BIT]) |=> rawm[17]);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw0 & en0) == 32'b0) |-> !irq_line0);

  assert_eoi_misc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_EOI && bus_wdata[0]) |=> !irq_misc);

  assert_core_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |=> raw0[0]);

endmodule

// File: tb/otg_evt_irq_bench.sv
module otg_evt_irq_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0]  wv = 0;
  logic        otg = 0, cirq = 0;
  logic        irq_line0, irq_misc;
  int          errors = 0, checks = 0;

  always #10 clk = ~clk;

  otg_evt_irq u_otg_evt_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vbus_drive(wv[0]), .vbus_charge(wv[1]), .vbus_discharge(wv[2]),
    .id_pullup_en(wv[3]), .core_otg_evt(otg), .core_irq(cirq),
    .irq_line0(irq_line0), .irq_misc(irq_misc));

  logic [31:0] m_raw0, m_rawm, m_en0, m_enm, m_cfg, evm, c0, cm;
  logic [3:0]  m_pw;
  logic        m_h0, m_h1, wrm;
  int          rpos[4] = '{13, 12, 11, 8};
  int          fpos[4] = '{5, 4, 3, 0};
  localparam logic [31:0] MM = 32'h0003_3939;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw0 = 0; m_rawm = 0; m_en0 = 0; m_enm = 0; m_cfg = 0;
      m_pw = 0; m_h0 = 0; m_h1 = 0;
    end else begin
      evm = 0;
      for (int i = 0; i < 4; i++) begin
        if (wv[i] && !m_pw[i]) evm[rpos[i]] = 1'b1;
        if (!wv[i] && m_pw[i]) evm[fpos[i]] = 1'b1;
      end
      if (otg) evm[16] = 1'b1;
      wrm = bus_sel && bus_we;
      if (wrm && bus_addr == 8'h10 && m_cfg[16] && !bus_wdata[16]) evm[17] = 1'b1;
      c0 = (wrm && bus_addr == 8'h28) ? bus_wdata : 0;
      cm = (wrm && bus_addr == 8'h38) ? bus_wdata : 0;
      m_raw0 = ((m_raw0 & ~c0) | {31'b0, cirq}) & 32'h1;
      m_rawm = ((m_rawm & ~cm) | evm) & MM;
      if (wrm && bus_addr == 8'h2C) m_en0 = (m_en0 | bus_wdata) & 32'h1;
      if (wrm && bus_addr == 8'h30) m_en0 = m_en0 & ~bus_wdata;
      if (wrm && bus_addr == 8'h3C) m_enm = (m_enm | bus_wdata) & MM;
      if (wrm && bus_addr == 8'h40) m_enm = m_enm & ~bus_wdata;
      if (wrm && bus_addr == 8'h10) m_cfg = bus_wdata & 32'h1_0000;
      m_h0 = wrm && bus_addr == 8'h20 && !bus_wdata[0];
      m_h1 = wrm && bus_addr == 8'h20 && bus_wdata[0];
      m_pw = wv;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h10: return m_cfg;
      8'h24: return m_raw0;
      8'h28: return m_raw0 & m_en0;
      8'h2C, 8'h30: return m_en0;
      8'h34: return m_rawm;
      8'h38: return m_rawm & m_enm;
      8'h3C, 8'h40: return m_enm;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R9 irq_line0", {31'b0, irq_line0}, {31'b0, ((m_raw0 & m_en0) != 0) && !m_h0});
    chk("R9 irq_misc", {31'b0, irq_misc}, {31'b0, ((m_rawm & m_enm) != 0) && !m_h1});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, mread(a));
    bus_sel = 0;
  endtask

  task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(20ns * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1;
    foreach (rpos[i]) begin end
    rdx(8'h24, 0, "R1 raw0"); rdx(8'h34, 0, "R1 rawm"); rdx(8'h3C, 0, "R1 enm");
    rdx(8'h2C, 0, "R1 en0"); rdx(8'h10, 0, "R1 cfg");
    chk("R1 outputs", {30'b0, irq_line0, irq_misc}, 0);

    wr(8'h3C, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    rdx(8'h3C, 32'h0003_3939, "R7 enm set"); rdx(8'h40, 32'h0003_3939, "R7 enm clr view");
    rdx(8'h30, 32'h1, "R7 en0");

    wv[0] = 1; tick(1); rdx(8'h34, 32'h0000_2000, "R2 drive rise");
    wv[1] = 1; tick(1); wv[2] = 1; tick(1); wv[3] = 1; tick(1);
    rdx(8'h34, 32'h0000_3900, "R2 all rises");
    wr(8'h38, 32'h0000_3900); rdx(8'h38, 0, "R8 w1c misc");
    chk("R9 misc low after clear", {31'b0, irq_misc}, 0);

    wv[0] = 0; tick(1); rdx(8'h34, 32'h20, "R3 drive fall");
    wv[3] = 0; tick(1); rdx(8'h34, 32'h21, "R3 id fall");
    wv[1] = 0; wv[2] = 0; tick(1); rd(8'h34, "R3 charge/discharge fall");

    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, "R8 raw write ignored");
    rdx(8'h34, 32'h39, "R8 raw write ignored literal");

    @(negedge clk); wv[0] = 1; bus_sel = 1; bus_we = 1; bus_addr = 8'h38; bus_wdata = 32'h2000;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    rdx(8'h34, 32'h2039, "R8 set wins over clear");

    @(negedge clk); otg = 1; @(negedge clk); otg = 0;
    rd(8'h34, "R4 otg event"); tick(2); rd(8'h34, "R4 otg sticky");
    @(negedge clk); cirq = 1; @(negedge clk); cirq = 0;
    rdx(8'h24, 32'h1, "R4 core irq"); rd(8'h28, "R6 masked line0");

    wr(8'h10, 32'h0); rd(8'h34, "R5 no event when already clear");
    wr(8'h10, 32'h0001_0000); rdx(8'h10, 32'h0001_0000, "R5 cfg flag");
    wr(8'h10, 32'h0); rd(8'h34, "R5 clear event");
    rdx(8'h10, 0, "R5 cfg cleared");

    wr(8'h40, 32'h0001_0000); rd(8'h38, "R6 masked misc"); rd(8'h3C, "R7 clear one");
    wr(8'h3C, 32'h0); wr(8'h40, 32'h0); rd(8'h3C, "R7 zero writes no effect");

    wr(8'h20, 32'h1);
    #1 chk("R10 misc acked", {31'b0, irq_misc}, 0);
    chk("R10 line0 untouched", {31'b0, irq_line0}, 1);
    tick(1); chk("R10 misc back", {31'b0, irq_misc}, 1);
    wr(8'h20, 32'h0);
    #1 chk("R10 line0 acked", {31'b0, irq_line0}, 0);
    rdx(8'h20, 0, "R10 eoi reads zero");
    tick(1); chk("R10 line0 back", {31'b0, irq_line0}, 1);

    wr(8'h28, 32'h1); wr(8'h38, mread(8'h34));
    rd(8'h38, "R8 clear all misc"); rd(8'h28, "R8 clear line0");
    wr(8'h30, 32'h1); @(negedge clk); cirq = 1; @(negedge clk); cirq = 0;
    rd(8'h24, "R6 raw set while disabled"); rd(8'h28, "R6 masked zero while disabled");
    tick(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule